// File: doc/BRIEF.md
# Timestamped Capture Cluster Packer

The block sits between the input samplers of a logic analyser and the sample memory. It takes sub-samples of up to sixteen logic channels, one per accepted strobe, and packs them into 16-bit event words. Each event word spans one event period. In the wide mode that word holds one sample of each of sixteen channels. In the two fast modes it holds two or four time-ordered sub-samples of each of eight or four channels. The sub-samples are bit-interleaved, so that bit `channel * samples_per_event + k` carries sub-sample `k` of that channel.

Seven consecutive events and a leading 16-bit timestamp form a 16-byte cluster. The cluster is presented as a 128-bit little-endian word with a one-cycle valid strobe. The timestamp is a free-running count of completed events. Any gap between the stamps of consecutive clusters larger than seven therefore marks event periods that were not stored, and a reader fills them by repeating the last sample. A position counter places each cluster within a 64-cluster (1024-byte) chunk and counts finished chunks.

Capture runs while `run` is high. Dropping `run` discards any partial event and any partial cluster. The mode select is sampled only while `run` is low.

Top module: `cap_cluster_packer`

## Requirements
- R1: After reset `clu_valid` and `chunk_done` are 0, `clu_slot` and `chunk_cnt` are 0, and the event count starts at 0, so the first cluster's timestamp is 0.
- R2: Cluster layout is little-endian. `clu_data[15:0]` is the timestamp. `clu_data[16*(e+1)+15 : 16*(e+1)]` is event word `e`, for `e` = 0..6 in time order.
- R3: Mode encoding sets the samples per event S and the channel count 16/S: `mode_sel` 0 or 3 gives S=1 with 16 channels, 1 gives S=2 with 8 channels, 2 gives S=4 with 4 channels. Event bit `c*S+k` is `sub_data[c]` of the k-th accepted sub-sample (k from 0) of that event.
- R4: `sub_data` bits at channel index 16/S and above have no effect on any event word.
- R5: A cluster's timestamp is the number of events completed since reset, modulo 2^16, at its first event. Clusters within an uninterrupted run therefore differ by 7, and the count wraps from 0xFFFF to 0.
- R6: `clu_valid` is a one-cycle pulse, high in the second cycle after the clock edge that accepts the last sub-sample of the seventh event. Every completed cluster is emitted exactly once.
- R7: `sub_data` is ignored in cycles where `sub_valid` is low or `run` is low. Idle cycles between sub-samples do not change the packed result.
- R8: Lowering `run` discards a partial event and a partial cluster. Events already completed in a discarded cluster still advance the timestamp, so the next cluster's stamp exceeds the previous one's by more than 7.
- R9: `mode_sel` is taken only while `run` is low. A change of `mode_sel` while `run` is high has no effect.
- R10: `clu_slot` gives the 0..63 position of the presented cluster within its chunk. `chunk_done` is high together with the 64th cluster of a chunk. `chunk_cnt` increments after that cluster and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Capture enable; low discards partial event and cluster |
| mode_sel | input | 2 | Channel mode, sampled while `run` is low |
| sub_valid | input | 1 | A sub-sample is present on `sub_data` |
| sub_data | input | 16 | One sub-sample, bit c = channel c |
| clu_valid | output | 1 | One-cycle strobe: `clu_data` holds a cluster |
| clu_data | output | 128 | Timestamp and seven event words, little-endian |
| clu_slot | output | 6 | Position of the presented cluster in its chunk |
| chunk_cnt | output | 16 | Number of completed chunks |
| chunk_done | output | 1 | Presented cluster is the last of its chunk |

## Verification
Each of the three modes is fed literal sub-sample patterns whose interleaved event words are known in advance. Channel-specific bits separate the `c*S+k` ordering from a plain concatenation, and garbage in the upper bits exposes any leak from unused channels. Sub-samples are also sent with irregular idle gaps, with `run` low and across a mode change made mid-run. These patterns show whether validity gating and mode latching hold. A stop in the middle of a partial event and cluster, followed by a restart, separates a timestamp that counts discarded events from one that does not. A long continuous run crosses chunk boundaries and the 16-bit timestamp wrap.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        MODE_CH16  = 2'd0,
        MODE_CH8   = 2'd1,
        MODE_CH4   = 2'd2,
        MODE_CH16B = 2'd3
    } cap_mode_e;

    // widest interleave is 2**SPE_LOG2_MAX sub-samples per event
    localparam int SPE_LOG2_MAX = 2;

    function automatic int spe_log2(input cap_mode_e m);
        case (m)
            MODE_CH8: return 1;
            MODE_CH4: return 2;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/cap_interleave.sv
module cap_interleave
    import cap_pkg::*;
#(
    parameter int EVT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  cap_mode_e        mode_i,
    input  logic             sub_valid_i,
    input  logic [EVT_W-1:0] sub_data_i,
    output logic             evt_valid_o,
    output logic [EVT_W-1:0] evt_word_o
);

    localparam int KW = SPE_LOG2_MAX;

    typedef struct packed {
        logic [KW-1:0]    k;
        logic [EVT_W-1:0] word;
        logic             vld;
    } il_state_t;

    il_state_t s_d, s_q;
    int        lg;
    logic [KW-1:0] k_last;

    assign lg     = spe_log2(mode_i);
    assign k_last = KW'((1 << lg) - 1);

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!run_i) begin
            s_d.k = '0;
        end else if (sub_valid_i) begin
            // bit b belongs to channel b>>lg, sub-sample b&(S-1)
            for (int b = 0; b < EVT_W; b++) begin
                if ((b & ((1 << lg) - 1)) == int'(s_q.k)) begin
                    s_d.word[b] = sub_data_i[b >> lg];
                end
            end
            if (s_q.k == k_last) begin
                s_d.k   = '0;
                s_d.vld = 1'b1;
            end else begin
                s_d.k = s_q.k + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // the word register is complete during the strobe cycle
    assign evt_valid_o = s_q.vld;
    assign evt_word_o  = s_q.word;

endmodule

// File: rtl/cap_cluster_asm.sv
module cap_cluster_asm #(
    parameter int EVT_W  = 16,
    parameter int EVENTS = 7,
    parameter int TS_W   = 16,
    localparam int EW    = $clog2(EVENTS),
    localparam int CLU_W = TS_W + EVENTS * EVT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             evt_valid_i,
    input  logic [EVT_W-1:0] evt_word_i,
    output logic             clu_valid_o,
    output logic [CLU_W-1:0] clu_data_o,
    output logic [TS_W-1:0]  ts_o
);

    typedef struct packed {
        logic [EW-1:0]                  e;
        logic [TS_W-1:0]                ts;
        logic [TS_W-1:0]                first;
        logic [EVENTS-1:0][EVT_W-1:0]   evs;
        logic                           vld;
    } ca_state_t;

    ca_state_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        if (evt_valid_i) begin
            c_d.ts = c_q.ts + 1'b1;
        end
        if (!run_i) begin
            c_d.e = '0;
        end else if (evt_valid_i) begin
            if (c_q.e == '0) begin
                c_d.first = c_q.ts;
            end
            c_d.evs[c_q.e] = evt_word_i;
            if (c_q.e == EW'(EVENTS - 1)) begin
                c_d.e   = '0;
                c_d.vld = 1'b1;
            end else begin
                c_d.e = c_q.e + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // slot storage stays untouched during the strobe cycle, so it is the output
    assign clu_valid_o = c_q.vld;
    assign clu_data_o  = {c_q.evs, c_q.first};
    assign ts_o        = c_q.ts;

endmodule

// File: rtl/cap_chunk_track.sv
module cap_chunk_track #(
    parameter int CLUSTERS_PER_CHUNK = 64,
    parameter int CHUNK_W            = 16,
    localparam int SLOT_W            = $clog2(CLUSTERS_PER_CHUNK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clu_valid_i,
    output logic [SLOT_W-1:0]  slot_o,
    output logic [CHUNK_W-1:0] chunk_o,
    output logic               chunk_done_o
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(CLUSTERS_PER_CHUNK - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic [CHUNK_W-1:0] chunk;
    } ct_state_t;

    ct_state_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clu_valid_i) begin
            if (t_q.slot == SLOT_LAST) begin
                t_d.slot  = '0;
                t_d.chunk = t_q.chunk + 1'b1;
            end else begin
                t_d.slot = t_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign slot_o       = t_q.slot;
    assign chunk_o      = t_q.chunk;
    assign chunk_done_o = clu_valid_i && (t_q.slot == SLOT_LAST);

endmodule

// File: rtl/cap_cluster_packer.sv
module cap_cluster_packer
    import cap_pkg::*;
#(
    parameter int EVT_W              = 16,
    parameter int EVENTS             = 7,
    parameter int TS_W               = 16,
    parameter int CLUSTERS_PER_CHUNK = 64,
    parameter int CHUNK_W            = 16,
    localparam int CLU_W             = TS_W + EVENTS * EVT_W,
    localparam int SLOT_W            = $clog2(CLUSTERS_PER_CHUNK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [1:0]         mode_sel,
    input  logic               sub_valid,
    input  logic [EVT_W-1:0]   sub_data,
    output logic               clu_valid,
    output logic [CLU_W-1:0]   clu_data,
    output logic [SLOT_W-1:0]  clu_slot,
    output logic [CHUNK_W-1:0] chunk_cnt,
    output logic               chunk_done
);

    cap_mode_e        mode_d, mode_q;
    logic             evt_valid;
    logic [EVT_W-1:0] evt_word;
    logic [TS_W-1:0]  ts_now;

    // mode is only taken while capture is idle
    always_comb begin
        mode_d = run ? mode_q : cap_mode_e'(mode_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_CH16;
        else        mode_q <= mode_d;
    end

    cap_interleave #(.EVT_W(EVT_W)) u_il (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .mode_i      (mode_q),
        .sub_valid_i (sub_valid),
        .sub_data_i  (sub_data),
        .evt_valid_o (evt_valid),
        .evt_word_o  (evt_word)
    );

    cap_cluster_asm #(.EVT_W(EVT_W), .EVENTS(EVENTS), .TS_W(TS_W)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .evt_valid_i (evt_valid),
        .evt_word_i  (evt_word),
        .clu_valid_o (clu_valid),
        .clu_data_o  (clu_data),
        .ts_o        (ts_now)
    );

    cap_chunk_track #(.CLUSTERS_PER_CHUNK(CLUSTERS_PER_CHUNK), .CHUNK_W(CHUNK_W)) u_ct (
        .clk          (clk),
        .rst_n        (rst_n),
        .clu_valid_i  (clu_valid),
        .slot_o       (clu_slot),
        .chunk_o      (chunk_cnt),
        .chunk_done_o (chunk_done)
    );

endmodule

// File: rtl/cap_cluster_packer_chk.sv
module cap_cluster_packer_chk #(
    parameter int TS_W               = 16,
    parameter int EVENTS             = 7,
    parameter int CLUSTERS_PER_CHUNK = 64,
    parameter int CHUNK_W            = 16,
    localparam int SLOT_W            = $clog2(CLUSTERS_PER_CHUNK)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run,
    input logic               sub_valid,
    input logic               evt_valid,
    input logic [1:0]         mode_q,
    input logic               clu_valid,
    input logic [TS_W-1:0]    clu_ts,
    input logic [TS_W-1:0]    ts_now,
    input logic [SLOT_W-1:0]  clu_slot,
    input logic [CHUNK_W-1:0] chunk_cnt,
    input logic               chunk_done
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(CLUSTERS_PER_CHUNK - 1);

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clu_valid |=> !clu_valid);

    p_evt_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ($past(sub_valid) && $past(run)));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(mode_q));

    p_ts_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clu_valid |-> ((ts_now - clu_ts) == TS_W'(EVENTS)));

    p_slot_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clu_valid |=> (clu_slot == (($past(clu_slot) == SLOT_LAST) ? '0 : $past(clu_slot) + 1'b1)));

    p_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clu_valid |=> $stable(clu_slot));

    p_chunk_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |=> (chunk_cnt == CHUNK_W'($past(chunk_cnt) + 1'b1)));

    p_chunk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !chunk_done |=> $stable(chunk_cnt));

endmodule

bind cap_cluster_packer cap_cluster_packer_chk #(
    .TS_W               (TS_W),
    .EVENTS             (EVENTS),
    .CLUSTERS_PER_CHUNK (CLUSTERS_PER_CHUNK),
    .CHUNK_W            (CHUNK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .sub_valid  (sub_valid),
    .evt_valid  (evt_valid),
    .mode_q     (mode_q),
    .clu_valid  (clu_valid),
    .clu_ts     (clu_data[TS_W-1:0]),
    .ts_now     (ts_now),
    .clu_slot   (clu_slot),
    .chunk_cnt  (chunk_cnt),
    .chunk_done (chunk_done)
);

// File: tb/cap_cluster_packer_test.sv
`timescale 1ns/1ps
module cap_cluster_packer_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic         sub_valid = 1'b0;
    logic [15:0]  sub_data = '0;
    logic         clu_valid;
    logic [127:0] clu_data;
    logic [5:0]   clu_slot;
    logic [15:0]  chunk_cnt;
    logic         chunk_done;

    cap_cluster_packer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_sel(mode_sel),
        .sub_valid(sub_valid), .sub_data(sub_data), .clu_valid(clu_valid),
        .clu_data(clu_data), .clu_slot(clu_slot), .chunk_cnt(chunk_cnt),
        .chunk_done(chunk_done)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [127:0] data;
        logic [5:0]   slot;
        logic [15:0]  chunk;
        logic         done;
    } exp_t;

    exp_t         expq[$];
    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;
    string        cur_req = "R2";
    logic [127:0] last_clu = '0;

    // bench model state
    int          m_k = 0;
    int          m_e = 0;
    int          m_lg = 0;
    int          m_clu = 0;
    bit          m_run = 1'b0;
    logic [15:0] m_ev = '0;
    logic [15:0] m_ts = '0;
    logic [15:0] m_first = '0;
    logic [15:0] m_evs [7];

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && clu_valid) begin
            last_clu = clu_data;
            if (expq.size() == 0) begin
                check("R6", "unexpected cluster", {127'd0, clu_valid}, 128'd0);
            end else begin
                exp_t x;
                x = expq.pop_front();
                check(cur_req, "cluster data", clu_data, x.data);
                check("R10", "slot", {122'd0, clu_slot}, {122'd0, x.slot});
                check("R10", "chunk count", {112'd0, chunk_cnt}, {112'd0, x.chunk});
                check("R10", "chunk done", {127'd0, chunk_done}, {127'd0, x.done});
            end
        end
    end

    function automatic int lg_of(input logic [1:0] m);
        return (m == 2'd1) ? 1 : (m == 2'd2) ? 2 : 0;
    endfunction

    task automatic model_sub(input logic [15:0] d);
        int s;
        exp_t x;
        s = 1 << m_lg;
        for (int c = 0; c < (16 >> m_lg); c++) m_ev[c * s + m_k] = d[c];
        m_k++;
        if (m_k == s) begin
            m_k = 0;
            if (m_e == 0) m_first = m_ts;
            m_evs[m_e] = m_ev;
            m_ts = m_ts + 16'd1;
            m_e++;
            if (m_e == 7) begin
                m_e = 0;
                x.data[15:0] = m_first;
                for (int i = 0; i < 7; i++) x.data[16 * (i + 1) +: 16] = m_evs[i];
                x.slot  = 6'(m_clu % 64);
                x.chunk = 16'(m_clu / 64);
                x.done  = ((m_clu % 64) == 63);
                expq.push_back(x);
                m_clu++;
            end
        end
    endtask

    task automatic drive_sub(input logic [15:0] d);
        @(negedge clk);
        sub_valid = 1'b1;
        sub_data  = d;
        if (m_run) model_sub(d);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sub_valid = 1'b0;
            sub_data  = 16'($urandom);
        end
    endtask

    task automatic set_run(input bit b);
        if (!b) idle(2);
        @(negedge clk);
        sub_valid = 1'b0;
        run = b;
        m_run = b;
        if (!b) begin
            m_k = 0;
            m_e = 0;
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        sub_valid = 1'b0;
        mode_sel = m;
        if (!m_run) m_lg = lg_of(m);
    endtask

    task automatic t_reset();
        check("R1", "valid after reset", {127'd0, clu_valid}, 128'd0);
        check("R1", "done after reset", {127'd0, chunk_done}, 128'd0);
        check("R1", "slot after reset", {122'd0, clu_slot}, 128'd0);
        check("R1", "chunk after reset", {112'd0, chunk_cnt}, 128'd0);
    endtask

    task automatic t_mode16();
        cur_req = "R1";
        set_mode(2'd0);
        set_run(1'b1);
        drive_sub(16'hBEEF);
        for (int i = 1; i < 7; i++) drive_sub(16'($urandom));
        idle(3);
        check("R1", "first timestamp", {112'd0, last_clu[15:0]}, 128'd0);
        check("R3", "16ch event word", {112'd0, last_clu[31:16]}, {112'd0, 16'hBEEF});
        cur_req = "R2";
        for (int i = 0; i < 14; i++) drive_sub(16'($urandom));
        idle(3);
        set_run(1'b0);
    endtask

    task automatic t_latency();
        cur_req = "R6";
        set_run(1'b1);
        for (int i = 0; i < 7; i++) drive_sub(16'($urandom));
        @(negedge clk);
        sub_valid = 1'b0;
        check("R6", "valid one cycle after", {127'd0, clu_valid}, 128'd0);
        @(negedge clk);
        check("R6", "valid two cycles after", {127'd0, clu_valid}, 128'd1);
        @(negedge clk);
        check("R6", "valid three cycles after", {127'd0, clu_valid}, 128'd0);
        set_run(1'b0);
    endtask

    task automatic t_mode8();
        cur_req = "R3";
        set_mode(2'd1);
        set_run(1'b1);
        drive_sub(16'h00AA); drive_sub(16'h0055);
        drive_sub(16'hFF00); drive_sub(16'hFF00);
        for (int i = 0; i < 10; i++) drive_sub(16'($urandom));
        idle(3);
        check("R3", "8ch interleave", {112'd0, last_clu[31:16]}, {112'd0, 16'h6666});
        check("R4", "8ch upper bits", {112'd0, last_clu[47:32]}, 128'd0);
        cur_req = "R4";
        for (int i = 0; i < 28; i++) drive_sub(16'($urandom));
        idle(3);
        set_run(1'b0);
    endtask

    task automatic t_mode4();
        cur_req = "R3";
        set_mode(2'd2);
        set_run(1'b1);
        drive_sub(16'h0001); drive_sub(16'h0002);
        drive_sub(16'h0004); drive_sub(16'h0008);
        repeat (4) drive_sub(16'hFFF0);
        for (int i = 0; i < 20; i++) drive_sub(16'($urandom));
        idle(3);
        check("R3", "4ch interleave", {112'd0, last_clu[31:16]}, {112'd0, 16'h8421});
        check("R4", "4ch upper bits", {112'd0, last_clu[47:32]}, 128'd0);
        set_run(1'b0);
    endtask

    task automatic t_gaps();
        cur_req = "R7";
        set_mode(2'd1);
        set_run(1'b1);
        for (int i = 0; i < 28; i++) begin
            drive_sub(16'($urandom));
            idle(i % 4);
        end
        idle(3);
        set_run(1'b0);
    endtask

    task automatic t_stop_restart();
        logic [15:0] ts_a;
        cur_req = "R8";
        set_mode(2'd2);
        set_run(1'b1);
        for (int i = 0; i < 28; i++) drive_sub(16'($urandom));
        idle(3);
        ts_a = last_clu[15:0];
        for (int i = 0; i < 13; i++) drive_sub(16'($urandom));
        set_run(1'b0);
        for (int i = 0; i < 5; i++) drive_sub(16'($urandom));
        idle(1);
        check("R7", "no cluster while stopped", 128'(expq.size()), 128'd0);
        set_run(1'b1);
        for (int i = 0; i < 28; i++) drive_sub(16'($urandom));
        idle(3);
        check("R8", "restart timestamp gap", {112'd0, last_clu[15:0]},
              {112'd0, 16'(ts_a + 16'd10)});
        set_run(1'b0);
    endtask

    task automatic t_mode_change();
        cur_req = "R9";
        set_mode(2'd0);
        set_run(1'b1);
        set_mode(2'd2);
        drive_sub(16'h1234);
        for (int i = 1; i < 7; i++) drive_sub(16'($urandom));
        idle(3);
        check("R9", "mode held while running", {112'd0, last_clu[31:16]}, {112'd0, 16'h1234});
        set_run(1'b0);
        set_mode(2'd3);
        cur_req = "R3";
        set_run(1'b1);
        drive_sub(16'hA5C3);
        for (int i = 1; i < 7; i++) drive_sub(16'($urandom));
        idle(3);
        check("R3", "mode 3 as 16ch", {112'd0, last_clu[31:16]}, {112'd0, 16'hA5C3});
        set_run(1'b0);
    endtask

    task automatic t_chunk();
        int target;
        cur_req = "R10";
        set_mode(2'd0);
        set_run(1'b1);
        target = ((m_clu / 64) + 2) * 64;
        while (m_clu < target) drive_sub(16'($urandom));
        idle(3);
        check("R10", "chunk count after boundary", {112'd0, chunk_cnt}, 128'(target / 64));
        check("R10", "slot after boundary", {122'd0, clu_slot}, 128'd0);
        set_run(1'b0);
    endtask

    task automatic t_wrap();
        cur_req = "R5";
        set_run(1'b1);
        for (int i = 0; i < 65600; i++) drive_sub(16'($urandom));
        idle(3);
        set_run(1'b0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode16();
        t_latency();
        t_mode8();
        t_mode4();
        t_gaps();
        t_stop_restart();
        t_mode_change();
        t_chunk();
        t_wrap();
        idle(4);
        check("R6", "clusters outstanding", 128'(expq.size()), 128'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule